// File: doc/BRIEF.md
# Bidirectional LCD Common Scan Shifter

This block produces the row-select pattern for one slice of rows of a dot-matrix LCD. A single scan bit is fed in, either by the display controller or by the neighbouring slice, and moves one row further on every rising edge of the line clock. The slice runs either as one long chain or as two independent half-length chains. The dual-chain form serves a panel split into an upper and a lower half, each scanned at half the duty. The scan direction can be reversed. The bit that leaves the far end of the chain fed by the outer pin is handed to the next slice.

The two side pads swap roles with the direction. The side the scan moves away from is an input. The side it moves towards drives the cascade bit and raises its output enable. The middle pad is an input only and feeds the second half-chain in dual mode. Every row is presented as a 2-bit drive-level code built from the row bit and the frame-inversion signal. A display-off input forces every row to the top level.

The block only works in common mode. The line clock is a plain input that is sampled and edge-detected in the system clock domain. Row codes come straight from the scan register and are not latched a second time.

Top module: `lcd_com_scan`

## Requirements
- R1: A synchronous reset clears every row bit. With `disp_en` high and `frame_inv` low, every row code is then 2'b01.
- R2: The register shifts by exactly one position only in the system cycle that follows a 0-to-1 change of `line_clk` while `com_mode` is high. A level held high does not shift again. Line-clock edges while `com_mode` is low leave every row unchanged.
- R3: Single chain (`dual_sel`=0) with `dir_rev`=0: row 1 takes `pad_l_i`, row k takes the old row k-1, and the cascade bit is row ROWS.
- R4: Single chain with `dir_rev`=1: row ROWS takes `pad_r_i`, row k takes the old row k+1, and the cascade bit is row 1.
- R5: Dual chain (`dual_sel`=1) with `dir_rev`=0: rows 1..ROWS/2 shift upward from `pad_l_i`, and rows ROWS/2+1..ROWS shift upward from `pad_m_i`. The cascade bit is row ROWS/2.
- R6: Dual chain with `dir_rev`=1: rows ROWS..ROWS/2+1 shift downward from `pad_r_i`, and rows ROWS/2..1 shift downward from `pad_m_i`. The cascade bit is row ROWS/2+1.
- R7: With `com_mode` high, `dir_rev`=0 drives the cascade bit on `pad_r_o` with `pad_r_oe`=1 and `pad_l_oe`=0. `dir_rev`=1 drives it on `pad_l_o` with `pad_l_oe`=1 and `pad_r_oe`=0. A pad that is not driving outputs 0. With `com_mode` low, both enables are 0.
- R8: Row r sits at `row_lvl[2r-1:2r-2]`. The codes are: row bit 1 with `frame_inv`=0 gives 2'b11 (bottom level); row bit 1 with `frame_inv`=1 gives 2'b00 (top level); row bit 0 with `frame_inv`=0 gives 2'b01 (upper-middle level); row bit 0 with `frame_inv`=1 gives 2'b10 (lower-middle level).
- R9: While `disp_en` is low, every row code is 2'b00, whatever the row bits and `frame_inv` are. The row bits are kept, and the codes return when `disp_en` goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| com_mode | input | 1 | Common mode select; scanning happens only while high |
| line_clk | input | 1 | Line clock; its rising edge advances the scan |
| dual_sel | input | 1 | 0 = one chain, 1 = two half-length chains |
| dir_rev | input | 1 | 0 = scan toward row ROWS, 1 = scan toward row 1 |
| frame_inv | input | 1 | Frame-inversion signal |
| disp_en | input | 1 | Display enable; low forces every row to the top level |
| pad_l_i | input | 1 | Left pad, input value |
| pad_m_i | input | 1 | Middle pad, input value (dual mode) |
| pad_r_i | input | 1 | Right pad, input value |
| pad_l_o | output | 1 | Left pad, cascade output value |
| pad_l_oe | output | 1 | Left pad output enable |
| pad_r_o | output | 1 | Right pad, cascade output value |
| pad_r_oe | output | 1 | Right pad output enable |
| row_lvl | output | 2*ROWS | Drive-level code per row, row 1 in the low bits |

## Verification
On every cycle, the assertions check four things. The register holds when no line-clock edge is detected, and no edge is ever taken outside common mode. After every shift, each entry point (left, middle or right pad, as set by the mode and direction) lands in its row, and the single-chain contents move by one. The pad enables are exclusive and follow the direction, and display-off forces all codes to the top level. The bench scenarios show what a single-cycle property cannot. These are full-length propagation, where a bit appears on the cascade pad only after exactly ROWS or ROWS/2 line clocks, and the complete level-code pattern across all rows for both frame polarities. They also show that a held-high line clock yields only one shift, and that the row contents survive a display-off interval.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;

  typedef enum logic [1:0] {
    LV_TOP   = 2'b00,
    LV_UPMID = 2'b01,
    LV_LOMID = 2'b10,
    LV_BOT   = 2'b11
  } lvl_e;

  // Drive level for one row from its scan bit, frame polarity and display enable.
  function automatic lvl_e com_level(input logic row_bit, input logic inv, input logic on);
    lvl_e r;
    if (!on)          r = LV_TOP;
    else if (row_bit) r = inv ? LV_TOP   : LV_BOT;
    else              r = inv ? LV_LOMID : LV_UPMID;
    return r;
  endfunction

  // Index of the stage whose content leaves as the cascade bit.
  function automatic int tail_index(input logic dual, input logic rev, input int rows);
    int r;
    if (!rev) r = dual ? (rows / 2) - 1 : rows - 1;
    else      r = dual ? (rows / 2)     : 0;
    return r;
  endfunction

endpackage

// File: rtl/lcd_edge_det.sv
module lcd_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic en_i,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= lvl_i;
  end

  assign pulse_o = en_i & lvl_i & ~lvl_q;
endmodule

// File: rtl/lcd_scan_reg.sv
module lcd_scan_reg #(
  parameter int ROWS = 80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            dual_i,
  input  logic            rev_i,
  input  logic            left_i,
  input  logic            mid_i,
  input  logic            right_i,
  output logic [ROWS-1:0] rows_o,
  output logic            casc_o
);
  import lcd_com_pkg::*;
  localparam int HALF = ROWS / 2;

  logic [ROWS-1:0] rows_q;
  logic [ROWS-1:0] nxt;

  for (genvar i = 0; i < ROWS; i++) begin : g_bit
    logic from_lo, from_hi;
    if (i == 0) begin : g_lo_edge
      assign from_lo = left_i;
    end else if (i == HALF) begin : g_lo_split
      assign from_lo = dual_i ? mid_i : rows_q[i-1];
    end else begin : g_lo_chain
      assign from_lo = rows_q[i-1];
    end
    if (i == ROWS - 1) begin : g_hi_edge
      assign from_hi = right_i;
    end else if (i == HALF - 1) begin : g_hi_split
      assign from_hi = dual_i ? mid_i : rows_q[i+1];
    end else begin : g_hi_chain
      assign from_hi = rows_q[i+1];
    end
    assign nxt[i] = rev_i ? from_hi : from_lo;
  end

  always_ff @(posedge clk) begin
    if (rst)         rows_q <= '0;
    else if (step_i) rows_q <= nxt;
  end

  assign rows_o = rows_q;
  assign casc_o = rows_q[tail_index(dual_i, rev_i, ROWS)];
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc #(
  parameter int ROWS = 80
) (
  input  logic [ROWS-1:0]   rows_i,
  input  logic              frame_inv_i,
  input  logic              disp_en_i,
  output logic [2*ROWS-1:0] lvl_o
);
  import lcd_com_pkg::*;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign lvl_o[2*i +: 2] = com_level(rows_i[i], frame_inv_i, disp_en_i);
  end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
  parameter int ROWS = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              com_mode,
  input  logic              line_clk,
  input  logic              dual_sel,
  input  logic              dir_rev,
  input  logic              frame_inv,
  input  logic              disp_en,
  input  logic              pad_l_i,
  input  logic              pad_m_i,
  input  logic              pad_r_i,
  output logic              pad_l_o,
  output logic              pad_l_oe,
  output logic              pad_r_o,
  output logic              pad_r_oe,
  output logic [2*ROWS-1:0] row_lvl
);
  // Named internal events, observed by the bound checker.
  logic            shift_evt;
  logic [ROWS-1:0] scan_q;
  logic            casc_bit;

  lcd_edge_det u_edge (
    .clk     (clk),
    .rst     (rst),
    .lvl_i   (line_clk),
    .en_i    (com_mode),
    .pulse_o (shift_evt)
  );

  lcd_scan_reg #(.ROWS(ROWS)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .step_i  (shift_evt),
    .dual_i  (dual_sel),
    .rev_i   (dir_rev),
    .left_i  (pad_l_i),
    .mid_i   (pad_m_i),
    .right_i (pad_r_i),
    .rows_o  (scan_q),
    .casc_o  (casc_bit)
  );

  lcd_level_enc #(.ROWS(ROWS)) u_enc (
    .rows_i      (scan_q),
    .frame_inv_i (frame_inv),
    .disp_en_i   (disp_en),
    .lvl_o       (row_lvl)
  );

  // The pad the scan travels towards becomes the cascade output.
  assign pad_l_oe = com_mode &  dir_rev;
  assign pad_r_oe = com_mode & ~dir_rev;
  assign pad_l_o  = pad_l_oe & casc_bit;
  assign pad_r_o  = pad_r_oe & casc_bit;
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
  parameter int ROWS = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              com_mode,
  input logic              dual_sel,
  input logic              dir_rev,
  input logic              disp_en,
  input logic              pad_l_i,
  input logic              pad_m_i,
  input logic              pad_r_i,
  input logic              pad_l_oe,
  input logic              pad_r_oe,
  input logic              shift_evt,
  input logic [ROWS-1:0]   scan_q,
  input logic [2*ROWS-1:0] row_lvl
);
  localparam int HALF = ROWS / 2;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> scan_q == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(scan_q));

  p_no_edge_off_r2: assert property (@(posedge clk) disable iff (rst)
    !com_mode |-> !shift_evt);

  p_single_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !dual_sel && !dir_rev) |=>
      (scan_q[0] == $past(pad_l_i)) && (scan_q[ROWS-1:1] == $past(scan_q[ROWS-2:0])));

  p_single_rev_r4: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !dual_sel && dir_rev) |=>
      (scan_q[ROWS-1] == $past(pad_r_i)) && (scan_q[ROWS-2:0] == $past(scan_q[ROWS-1:1])));

  p_dual_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && dual_sel && !dir_rev) |=>
      (scan_q[0] == $past(pad_l_i)) && (scan_q[HALF] == $past(pad_m_i)));

  p_dual_rev_r6: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && dual_sel && dir_rev) |=>
      (scan_q[ROWS-1] == $past(pad_r_i)) && (scan_q[HALF-1] == $past(pad_m_i)));

  p_pad_dir_r7: assert property (@(posedge clk) disable iff (rst)
    com_mode |-> ((pad_l_oe ^ pad_r_oe) && (pad_l_oe == dir_rev)));

  p_pad_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !com_mode |-> (!pad_l_oe && !pad_r_oe));

  p_blank_r9: assert property (@(posedge clk) disable iff (rst)
    !disp_en |-> (row_lvl == '0));
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.ROWS(ROWS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .com_mode  (com_mode),
  .dual_sel  (dual_sel),
  .dir_rev   (dir_rev),
  .disp_en   (disp_en),
  .pad_l_i   (pad_l_i),
  .pad_m_i   (pad_m_i),
  .pad_r_i   (pad_r_i),
  .pad_l_oe  (pad_l_oe),
  .pad_r_oe  (pad_r_oe),
  .shift_evt (shift_evt),
  .scan_q    (scan_q),
  .row_lvl   (row_lvl)
);

// File: tb/sim_lcd_com_scan.sv
`timescale 1ns/1ps
module sim_lcd_com_scan;
  localparam int ROWS = 80;
  localparam int HALF = ROWS / 2;
  localparam int NV   = 16;

  logic clk = 1'b0;
  logic rst, com_mode, line_clk, dual_sel, dir_rev, frame_inv, disp_en;
  logic pad_l_i, pad_m_i, pad_r_i;
  logic pad_l_o, pad_l_oe, pad_r_o, pad_r_oe;
  logic [2*ROWS-1:0] row_lvl;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  logic [ROWS-1:0] mdl;

  // Vector entries: {dual, dir, left, mid, right, frame_inv}
  localparam logic [5:0] VEC [NV] = '{
    6'b001000, 6'b000001, 6'b001000, 6'b000000,
    6'b010011, 6'b010000, 6'b010011, 6'b011100,
    6'b101100, 6'b100101, 6'b101000, 6'b100100,
    6'b110011, 6'b110101, 6'b111001, 6'b110010
  };

  always #4 clk = ~clk;

  lcd_com_scan #(.ROWS(ROWS)) u0 (
    .clk(clk), .rst(rst), .com_mode(com_mode), .line_clk(line_clk),
    .dual_sel(dual_sel), .dir_rev(dir_rev), .frame_inv(frame_inv), .disp_en(disp_en),
    .pad_l_i(pad_l_i), .pad_m_i(pad_m_i), .pad_r_i(pad_r_i),
    .pad_l_o(pad_l_o), .pad_l_oe(pad_l_oe), .pad_r_o(pad_r_o), .pad_r_oe(pad_r_oe),
    .row_lvl(row_lvl)
  );

  function automatic logic [1:0] want_code(input logic b, input logic m, input logic on);
    if (!on) return 2'b00;
    case ({b, m})
      2'b10:   return 2'b11;
      2'b11:   return 2'b00;
      2'b00:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2*ROWS-1:0] want_rows(input logic [ROWS-1:0] bits,
                                                  input logic m, input logic on);
    logic [2*ROWS-1:0] v;
    for (int k = 0; k < ROWS; k++) v[2*k +: 2] = want_code(bits[k], m, on);
    return v;
  endfunction

  function automatic logic want_tail(input logic [ROWS-1:0] bits, input logic d, input logic r);
    if (!r) return d ? bits[HALF-1] : bits[ROWS-1];
    return d ? bits[HALF] : bits[0];
  endfunction

  task automatic model_step(input logic d, input logic r, input logic l, input logic m, input logic rr);
    case ({d, r})
      2'b00: mdl = {mdl[ROWS-2:0], l};
      2'b01: mdl = {rr, mdl[ROWS-1:1]};
      2'b10: mdl = {mdl[ROWS-2:HALF], m, mdl[HALF-2:0], l};
      default: mdl = {rr, mdl[ROWS-1:HALF+1], m, mdl[HALF-1:1]};
    endcase
  endtask

  task automatic check_vec(input string tag, input logic [2*ROWS-1:0] act, input logic [2*ROWS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // One line-clock pulse; outputs are settled at the returning negedge.
  task automatic pulse(input logic d, input logic r, input logic l, input logic m,
                       input logic rr, input logic fi);
    @(negedge clk);
    dual_sel = d; dir_rev = r; pad_l_i = l; pad_m_i = m; pad_r_i = rr; frame_inv = fi;
    line_clk = 1'b1;
    @(negedge clk);
    line_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_tail(input string tag);
    if (!dir_rev) begin
      check_bit({tag, " right pad value"}, pad_r_o, want_tail(mdl, dual_sel, dir_rev));
      check_bit("R7 left pad idle", pad_l_o, 1'b0);
    end else begin
      check_bit({tag, " left pad value"}, pad_l_o, want_tail(mdl, dual_sel, dir_rev));
      check_bit("R7 right pad idle", pad_r_o, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; com_mode = 1'b1; line_clk = 1'b0; dual_sel = 1'b0; dir_rev = 1'b0;
    frame_inv = 1'b0; disp_en = 1'b1; pad_l_i = 1'b0; pad_m_i = 1'b0; pad_r_i = 1'b0;
    mdl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R7 pad roles for forward direction
    check_vec("R1 reset row codes", row_lvl, {ROWS{2'b01}});
    check_bit("R7 right enable fwd", pad_r_oe, 1'b1);
    check_bit("R7 left enable fwd", pad_l_oe, 1'b0);

    // Table walk: all four mode/direction combinations, both frame polarities (R3-R6, R8)
    for (int v = 0; v < NV; v++) begin
      logic [5:0] e;
      string tag;
      e = VEC[v];
      pulse(e[5], e[4], e[3], e[2], e[1], e[0]);
      model_step(e[5], e[4], e[3], e[2], e[1]);
      tag = e[5] ? (e[4] ? "R6" : "R5") : (e[4] ? "R4" : "R3");
      check_vec({tag, "/R8 row codes"}, row_lvl, want_rows(mdl, e[0], 1'b1));
      check_tail(tag);
    end
    check_bit("R7 left enable rev", pad_l_oe, 1'b1);
    check_bit("R7 right enable rev", pad_r_oe, 1'b0);

    // R2: held-high line clock gives a single shift
    @(negedge clk);
    dual_sel = 1'b0; dir_rev = 1'b0; pad_l_i = 1'b1; frame_inv = 1'b0; line_clk = 1'b1;
    repeat (5) @(negedge clk);
    line_clk = 1'b0;
    @(negedge clk);
    model_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check_vec("R2 held level one shift", row_lvl, want_rows(mdl, 1'b0, 1'b1));

    // R2/R7: no shift and no driven pad outside common mode
    @(negedge clk) com_mode = 1'b0;
    pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_vec("R2 ignored outside common mode", row_lvl, want_rows(mdl, 1'b0, 1'b1));
    check_bit("R7 left enable off", pad_l_oe, 1'b0);
    check_bit("R7 right enable off", pad_r_oe, 1'b0);
    check_bit("R7 right value off", pad_r_o, 1'b0);
    @(negedge clk) com_mode = 1'b1;

    // R9: display off forces top level; rows survive
    @(negedge clk) disp_en = 1'b0;
    @(negedge clk);
    check_vec("R9 display off codes", row_lvl, '0);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    model_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check_vec("R9 display off with inversion", row_lvl, '0);
    @(negedge clk) disp_en = 1'b1;
    @(negedge clk);
    check_vec("R9 codes restored", row_lvl, want_rows(mdl, 1'b1, 1'b1));

    // R1 mid-run reset, then R3 full-length cascade timing
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    mdl = '0;
    @(negedge clk);
    check_vec("R1 mid-run reset", row_lvl, want_rows(mdl, 1'b1, 1'b1));
    for (int k = 0; k < ROWS; k++) begin
      pulse(1'b0, 1'b0, (k == 0), 1'b0, 1'b0, 1'b0);
      model_step(1'b0, 1'b0, (k == 0), 1'b0, 1'b0);
      check_bit("R3 cascade after full chain", pad_r_o, (k == ROWS - 1));
    end

    // R6 half-length cascade timing from the right pad
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    mdl = '0;
    for (int k = 0; k < HALF; k++) begin
      pulse(1'b1, 1'b1, 1'b0, 1'b1, (k == 0), 1'b0);
      model_step(1'b1, 1'b1, 1'b0, 1'b1, (k == 0));
      check_bit("R6 cascade after half chain", pad_l_o, (k == HALF - 1));
    end
    check_vec("R6 middle-fed half filled", row_lvl, want_rows(mdl, 1'b0, 1'b1));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule